// File: doc/BRIEF.md
# Charge-Balance Converter Sequencing Controller

This block is the digital half of an up/down integrating (charge-balance) voltmeter. On every clock it reads a one-bit comparator from the analog integrator and drives a single up/down control line back to it. The line follows one of two fixed eight-clock patterns. The pattern for each frame is picked from the comparator level seen on the last clock of the frame before. The pattern that is mostly low pulls the integrator down, and the pattern that is mostly high pushes it up, so the loop settles around its balance point. A signed four-digit BCD accumulator steps up or down on every clock, following the control line.

A conversion runs a fixed number of whole frames, then enters an override phase in which counting continues. The override ends on the first clock where the auto-zero flag, the control line and the comparator are all low. The block then moves the accumulator's magnitude, sign, underrange and overrange flags into an output latch and raises a one-clock result-valid pulse. In the same step it clears the accumulator, and the next conversion starts at once.

The result side is a valid-only stream with no back-pressure. The converter's pace is set by the analog loop and cannot be stalled. The latch holds each result unchanged until the next valid pulse, so a consumer has a whole conversion time to read it.

Top module: `cbc_ctrl`

## Requirements
- R1: A frame is 8 clocks (`FRAME_LEN`) long. In pattern A, `updn_o`=1 for the first clock and 0 for the other seven. In pattern B, `updn_o`=1 for the first seven clocks and 0 for the last. `updn_o`=1 means count up.
- R2: The pattern of each frame is chosen from `cmp_i` on the last clock of the previous frame: 1 selects A and 0 selects B. The first frame after a clear uses `cmp_i` as seen on the transfer clock.
- R3: While counting, the accumulator moves by +1 on each clock with `updn_o`=1 and by -1 on each clock with `updn_o`=0. `result_bcd_o` carries the magnitude as BCD nibbles, with the thousands digit in bits [15:12] and the units digit in bits [3:0].
- R4: The measure interval lasts `MEAS_FRAMES` whole frames. The override phase begins on the next frame boundary and keeps counting.
- R5: The override ends on the first clock where `az_i`, `updn_o` and `cmp_i` are all 0. That clock is not counted.
- R6: `valid_o` is high for exactly one clock, two clocks after the stop clock. The new result outputs appear in that same clock.
- R7: The accumulator is cleared when the result is transferred. The next conversion starts from zero, with its first frame beginning in the clock where `valid_o` is high.
- R8: `under_o`=1 when the transferred magnitude is at most 100 (`UNDER_LIM`), and 0 above it.
- R9: `over_o`=1 when the transferred magnitude is greater than 1999 (`OVER_LIM`), and 0 at 1999 or below.
- R10: `sign_o`=1 marks a negative result. Counting down through zero flips the sign and the magnitude grows again from zero. Zero is always reported as positive.
- R11: `result_bcd_o`, `sign_o`, `under_o` and `over_o` change only in the clock where `valid_o` is high. After reset they read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_i | input | 1 | Comparator: 1 when the integrator is above the balance point |
| az_i | input | 1 | Auto-zero flag; holds the override phase open while high |
| updn_o | output | 1 | Up/down control line to the integrator |
| result_bcd_o | output | 16 | Latched magnitude, four BCD digits |
| sign_o | output | 1 | Latched polarity, 1 = negative |
| under_o | output | 1 | Latched underrange flag |
| over_o | output | 1 | Latched overrange flag |
| valid_o | output | 1 | One-clock pulse when a new result is latched |

## Verification
A phase counter off by one clock, or a pattern picked from the wrong comparator sample, shows up on `updn_o` within the same frame. It also shifts the final count by a multiple of two. A broken carry or borrow in one BCD digit appears only in the latched result, at the end of a conversion. So the scenarios end their counts just across the digit and threshold boundaries (99/100/101, 1999/2005) and through zero into negative values. A stop condition checked against the wrong signal moves the `valid_o` pulse by at least one clock, so the bench samples the pulse in exactly one cycle and checks that it is low in the cycle before.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_MEAS = 2'd1,
    ST_OVR  = 2'd2,
    ST_XFER = 2'd3
  } cbc_state_e;

endpackage

// File: rtl/cbc_frame_gen.sv
module cbc_frame_gen #(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned SHORT_HI  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic cmp_i,
  output logic updn_o,
  output logic frame_end_o
);

  localparam int unsigned PH_W = $clog2(FRAME_LEN);
  localparam logic [PH_W-1:0] LAST   = PH_W'(FRAME_LEN - 1);
  localparam logic [PH_W-1:0] A_HIGH = PH_W'(SHORT_HI);
  localparam logic [PH_W-1:0] B_HIGH = PH_W'(FRAME_LEN - SHORT_HI);

  logic [PH_W-1:0] phase;
  logic            pat_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      pat_a <= 1'b0;
    end else if (restart) begin
      phase <= '0;
      pat_a <= cmp_i;
    end else if (run) begin
      if (phase == LAST) begin
        phase <= '0;
        pat_a <= cmp_i;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    if (!run)       updn_o = 1'b0;
    else if (pat_a) updn_o = (phase < A_HIGH);
    else            updn_o = (phase < B_HIGH);
  end

  assign frame_end_o = run && (phase == LAST);

  // R1: both patterns start high and end low
  assert_frame_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == '0) |-> updn_o);
  assert_frame_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> !updn_o);
  // R2: pattern only changes on a frame boundary or restart
  assert_pat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && phase != LAST) |=> $stable(pat_a));

endmodule

// File: rtl/cbc_bcd_acc.sv
module cbc_bcd_acc #(
  parameter int unsigned DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  logic              up,
  output logic [4*DIGITS-1:0] mag_o,
  output logic              neg_o
);

  localparam int unsigned W = 4 * DIGITS;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]    mag_inc, mag_dec, nxt_mag;
  logic [DIGITS:0] cy, bw;
  logic            nxt_neg, grow;

  assign cy[0] = 1'b1;
  assign bw[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    assign d = mag_o[4*i +: 4];
    assign mag_inc[4*i +: 4] = cy[i] ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
    assign mag_dec[4*i +: 4] = bw[i] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
    assign cy[i+1] = cy[i] && (d == 4'd9);
    assign bw[i+1] = bw[i] && (d == 4'd0);

    assert_bcd_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      d <= 4'd9);
  end

  // magnitude grows when counting away from zero
  assign grow = up ^ neg_o;

  always_comb begin
    nxt_mag = mag_o;
    nxt_neg = neg_o;
    if (clear) begin
      nxt_mag = '0;
      nxt_neg = 1'b0;
    end else if (step_en) begin
      if (grow) begin
        if (!cy[DIGITS]) nxt_mag = mag_inc;
      end else if (bw[DIGITS]) begin
        nxt_neg = 1'b1;
        nxt_mag = ONE;
      end else begin
        nxt_mag = mag_dec;
        if (mag_o == ONE) nxt_neg = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_o <= '0;
      neg_o <= 1'b0;
    end else begin
      mag_o <= nxt_mag;
      neg_o <= nxt_neg;
    end
  end

  assert_no_negzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_o == '0) |-> !neg_o);
  assert_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mag_o == '0));

endmodule

// File: rtl/cbc_result_latch.sv
module cbc_result_latch #(
  parameter int unsigned DIGITS    = 4,
  parameter int unsigned UNDER_LIM = 100,
  parameter int unsigned OVER_LIM  = 1999
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [4*DIGITS-1:0] mag_i,
  input  logic                neg_i,
  output logic [4*DIGITS-1:0] bcd_o,
  output logic                sign_o,
  output logic                under_o,
  output logic                over_o,
  output logic                valid_o
);

  logic [31:0] bin;

  always_comb begin
    bin = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      bin = bin * 32'd10 + 32'(mag_i[4*i +: 4]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcd_o   <= '0;
      sign_o  <= 1'b0;
      under_o <= 1'b0;
      over_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load;
      if (load) begin
        bcd_o   <= mag_i;
        sign_o  <= neg_i;
        under_o <= (bin <= 32'(UNDER_LIM));
        over_o  <= (bin > 32'(OVER_LIM));
      end
    end
  end

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(bcd_o) && $stable(sign_o) && $stable(under_o) && $stable(over_o)));
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(under_o && over_o));

endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl #(
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned FRAME_LEN   = 8,
  parameter int unsigned SHORT_HI    = 1,
  parameter int unsigned MEAS_FRAMES = 178,
  parameter int unsigned UNDER_LIM   = 100,
  parameter int unsigned OVER_LIM    = 1999
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_i,
  input  logic                az_i,
  output logic                updn_o,
  output logic [4*DIGITS-1:0] result_bcd_o,
  output logic                sign_o,
  output logic                under_o,
  output logic                over_o,
  output logic                valid_o
);
  import cbc_pkg::*;

  localparam int unsigned CNT_W = $clog2(MEAS_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MEAS_FRAMES - 1);

  cbc_state_e          state;
  logic [CNT_W-1:0]    frame_cnt;
  logic                run, restart, stop, step_en, frame_end;
  logic [4*DIGITS-1:0] acc_mag;
  logic                acc_neg;

  assign run     = (state == ST_MEAS) || (state == ST_OVR);
  assign restart = (state == ST_SYNC) || (state == ST_XFER);
  assign stop    = (state == ST_OVR) && !az_i && !updn_o && !cmp_i;
  assign step_en = run && !stop;

  cbc_frame_gen #(
    .FRAME_LEN (FRAME_LEN),
    .SHORT_HI  (SHORT_HI)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .restart     (restart),
    .cmp_i       (cmp_i),
    .updn_o      (updn_o),
    .frame_end_o (frame_end)
  );

  cbc_bcd_acc #(
    .DIGITS (DIGITS)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == ST_XFER),
    .step_en (step_en),
    .up      (updn_o),
    .mag_o   (acc_mag),
    .neg_o   (acc_neg)
  );

  cbc_result_latch #(
    .DIGITS    (DIGITS),
    .UNDER_LIM (UNDER_LIM),
    .OVER_LIM  (OVER_LIM)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state == ST_XFER),
    .mag_i   (acc_mag),
    .neg_i   (acc_neg),
    .bcd_o   (result_bcd_o),
    .sign_o  (sign_o),
    .under_o (under_o),
    .over_o  (over_o),
    .valid_o (valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_SYNC;
      frame_cnt <= '0;
    end else begin
      unique case (state)
        ST_SYNC: begin
          state     <= ST_MEAS;
          frame_cnt <= '0;
        end
        ST_MEAS: begin
          if (frame_end) begin
            if (frame_cnt == CNT_LAST) begin
              state     <= ST_OVR;
              frame_cnt <= '0;
            end else begin
              frame_cnt <= frame_cnt + 1'b1;
            end
          end
        end
        ST_OVR: begin
          if (stop) state <= ST_XFER;
        end
        ST_XFER: begin
          state     <= ST_MEAS;
          frame_cnt <= '0;
        end
        default: state <= ST_SYNC;
      endcase
    end
  end

  // R5: nothing is counted once the stop clock has passed
  assert_no_step_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER) |-> !updn_o);
  // R6: the result pulse follows the stop clock by two clocks
  assert_valid_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OVR && !az_i && !updn_o && !cmp_i) |-> ##2 valid_o);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R4: the override phase is only entered from a frame boundary
  assert_ovr_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEAS && !frame_end) |=> (state == ST_MEAS));

endmodule

// File: tb/tb_cbc_ctrl.sv
module tb_cbc_ctrl;

  localparam int MEAS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_i = 1'b0;
  logic        az_i = 1'b0;
  logic        updn_o;
  logic [15:0] result_bcd_o;
  logic        sign_o, under_o, over_o, valid_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cbc_ctrl #(.MEAS_FRAMES(MEAS)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_i        (cmp_i),
    .az_i         (az_i),
    .updn_o       (updn_o),
    .result_bcd_o (result_bcd_o),
    .sign_o       (sign_o),
    .under_o      (under_o),
    .over_o       (over_o),
    .valid_o      (valid_o)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk_result(input string tag, input int val);
    int mag = (val < 0) ? -val : val;
    chk("R6", {tag, " valid"}, int'(valid_o), 1);
    chk("R3", {tag, " magnitude"}, int'(result_bcd_o), to_bcd(mag));
    chk("R10", {tag, " sign"}, int'(sign_o), (val < 0) ? 1 : 0);
    chk("R8", {tag, " underrange"}, int'(under_o), (mag <= 100) ? 1 : 0);
    chk("R9", {tag, " overrange"}, int'(over_o), (mag > 1999) ? 1 : 0);
  endtask

  task automatic wait_valid();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!valid_o && n < 20000);
    if (!valid_o) begin
      chk("R6", "timeout waiting for valid", 0, 1);
      finish_run();
    end
  endtask

  // Starts at the negedge of the valid cycle V; ends at the next valid cycle.
  // Auto-zero held high for k override frames, comparator low throughout.
  task automatic t_az_hold(input int k, input int expv);
    cmp_i = 1'b0;
    az_i  = 1'b1;
    repeat (134 + 8 * k) @(negedge clk);
    az_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6", $sformatf("k=%0d valid early", k), int'(valid_o), 0);
    @(negedge clk);
    chk_result($sformatf("az k=%0d", k), expv);
  endtask

  // R1 R2 R10: one B frame, then A frames drive the count negative
  task automatic t_negative();
    cmp_i = 1'b0;
    az_i  = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R1", $sformatf("pattern B clk %0d", i), int'(updn_o), (i < 7) ? 1 : 0);
      if (i == 7) cmp_i = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      chk("R2", $sformatf("pattern A clk %0d", i), int'(updn_o), (i == 0) ? 1 : 0);
      @(negedge clk);
    end
    repeat (131 - 16) @(negedge clk);
    cmp_i = 1'b0;
    @(negedge clk);
    chk("R5", "negative valid early", int'(valid_o), 0);
    @(negedge clk);
    chk_result("negative", -85);
  endtask

  // R8: second override frame switched to A, stopped at phase s
  task automatic t_under(input int s, input int expv);
    cmp_i = 1'b0;
    az_i  = 1'b1;
    repeat (135) @(negedge clk);
    cmp_i = 1'b1;
    repeat (1 + s) @(negedge clk);
    cmp_i = 1'b0;
    az_i  = 1'b0;
    @(negedge clk);
    chk("R5", $sformatf("under s=%0d valid early", s), int'(valid_o), 0);
    @(negedge clk);
    chk_result($sformatf("under s=%0d", s), expv);
  endtask

  // R6 R7 R11: pulse width, hold, and restart from zero
  task automatic t_pulse();
    int held;
    cmp_i = 1'b0;
    az_i  = 1'b0;
    held = int'(result_bcd_o);
    @(negedge clk);
    chk("R6", "valid pulse width", int'(valid_o), 0);
    repeat (60) @(negedge clk);
    chk("R11", "result held mid conversion", int'(result_bcd_o), held);
    wait_valid();
    chk("R7", "restart from zero", int'(result_bcd_o), to_bcd(103));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset result", int'(result_bcd_o), 0);
    chk("R11", "reset valid", int'(valid_o), 0);
    chk("R11", "reset sign", int'(sign_o), 0);
    chk("R1", "reset updn", int'(updn_o), 0);
    rst_n = 1'b1;
    wait_valid();
    chk_result("first conversion R4", 103);
    t_az_hold(0, 103);
    t_negative();
    t_under(3, 101);
    t_under(4, 100);
    t_under(5, 99);
    t_az_hold(2, 115);
    t_pulse();
    t_az_hold(316, 1999);
    t_az_hold(317, 2005);
    finish_run();
  end

endmodule